// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. A free-running tick at sixteen times the baud rate paces it. It brings the line into the clock domain and waits for a falling edge. It confirms the start bit at its midpoint, then samples every later bit at its centre. The character format comes from five control inputs: word length, stop-bit mode, parity enable, parity select and forced ("sticky") parity.

Each received character appears on an 8-bit output together with a one-clock valid strobe. Two error flags arrive in the same clock: one for parity and one for framing. An interrupt request pulses with them when line-status interrupts are enabled and the character carries an error. The forced parity mode lets one master address many receivers on a shared line. In that mode the parity slot is compared against the inverse of the select bit, not against a computed parity.

Top module: `serial_rx`

## Requirements
- R1: The word-length input selects the data bit count: 2'b00, 2'b01, 2'b10 and 2'b11 give 5, 6, 7 and 8 bits. Bits are received least significant first, and the output bits above the word length read zero.
- R2: With parity on and forced parity off, the bit after the last data bit is checked. Select 0 requires an odd count of ones over the data plus the parity bit, and select 1 requires an even count. A mismatch sets the parity-error flag.
- R3: With parity on and forced parity on, the parity slot must equal the inverse of the select bit: 1 when select is 0, and 0 when select is 1. Any other value sets the parity-error flag.
- R4: With parity off, no parity slot is expected and the stop bit directly follows the data. The select and forced-parity inputs have no effect, and the parity-error flag stays low.
- R5: Only the first stop bit is checked. With the two-stop-bit mode selected, a frame followed by a new start bit straight after one stop bit is received correctly, and so is the next frame.
- R6: A low level at the first stop-bit sample sets the framing-error flag.
- R7: A low pulse that is high again at the half-bit point, 8 ticks after detection, is not taken as a start bit, and no character is delivered.
- R8: The valid strobe lasts one clock, one clock after the stop-bit sample. The parity-error and framing-error flags are only ever high in that same clock.
- R9: The interrupt request pulses together with the valid strobe only when the line-status enable is 1 and the character has a parity or framing error. Otherwise it stays low.
- R10: After reset, the data output, the valid strobe, both flags and the interrupt request are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse at 16x the baud rate |
| rxd_i | input | 1 | Serial line, idles high |
| wlen_i | input | 2 | Word length select |
| stop2_i | input | 1 | Two-stop-bit mode (only the first is checked) |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | Parity select: 0 odd, 1 even |
| par_stick_i | input | 1 | Forced parity mode |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| data_o | output | 8 | Received character |
| valid_o | output | 1 | Character strobe, one clock |
| perr_o | output | 1 | Parity error for this character |
| ferr_o | output | 1 | Framing error for this character |
| irq_o | output | 1 | Error interrupt request pulse |

## Verification
The stop-bit sample falls about nine ticks into the stop bit. That is two synchroniser clocks plus up to one tick of detection delay, and then eight ticks to the start midpoint. The strobe, the flags and the interrupt pulse are due one clock after that sample. The bench captures every strobe at falling clock edges while a frame is in flight. It judges each frame only after two idle bit times, so the exact tick phase does not matter, and it requires exactly one strobe per frame and none for a rejected glitch. Back-to-back frames in two-stop-bit mode are both captured in order, which shows that no second stop bit was awaited.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned IDX_W  = $clog2(CHAR_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef logic [1:0] wlen_t;

  // 00..11 -> 5..8 data bits, returned as index of last bit
  function automatic logic [IDX_W-1:0] last_index(wlen_t w);
    return IDX_W'(4) + IDX_W'(w);
  endfunction
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[g] <= 1'b1;
      else if (g == 0) ff_q[g] <= d_i;
      else ff_q[g] <= ff_q[(g > 0) ? g - 1 : 0];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity import serial_rx_pkg::*; (
  input  logic [CHAR_W-1:0] data_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              exp_bit_o
);
  logic ones_odd;

  // unused upper bits are held at zero by the controller
  assign ones_odd = ^data_i;

  always_comb begin
    if (stick_i)     exp_bit_o = ~even_i;
    else if (even_i) exp_bit_o = ones_odd;
    else             exp_bit_o = ~ones_odd;
  end
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl import serial_rx_pkg::*; #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  wlen_t             wlen_i,
  input  logic              par_en_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              par_bit_o,
  output logic              stop_bit_o,
  output logic              done_o
);
  localparam int unsigned CNT_W     = $clog2(OVERSAMPLE);
  localparam int unsigned HALF_LAST = OVERSAMPLE / 2 - 1;
  localparam int unsigned FULL_LAST = OVERSAMPLE - 1;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] sr_q;
  logic              par_q;
  logic              at_half;
  logic              at_full;

  assign at_half = (cnt_q == CNT_W'(HALF_LAST));
  assign at_full = (cnt_q == CNT_W'(FULL_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      par_q   <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!line_i) begin
            state_q <= ST_START;
            sr_q    <= '0;
            par_q   <= 1'b0;
          end
        end
        ST_START: begin
          if (at_half) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= line_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_full) begin
            cnt_q       <= '0;
            sr_q[idx_q] <= line_i;
            if (idx_q == last_index(wlen_i)) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_full) begin
            cnt_q   <= '0;
            par_q   <= line_i;
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_full) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o     = sr_q;
  assign par_bit_o  = par_q;
  assign stop_bit_o = line_i;
  assign done_o     = tick_i && (state_q == ST_STOP) && at_full;
endmodule

// File: rtl/serial_rx.sv
module serial_rx import serial_rx_pkg::*; #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        wlen_i,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  input  logic              lsi_en_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              irq_o
);
  logic              line_s;
  logic [CHAR_W-1:0] char_w;
  logic              par_bit;
  logic              stop_bit;
  logic              done;
  logic              exp_par;
  logic              perr_d;
  logic              ferr_d;
  logic              stop2_unused;

  // receiver checks only the first stop bit whatever the mode
  assign stop2_unused = stop2_i;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_s),
    .wlen_i    (wlen_i),
    .par_en_i  (par_en_i),
    .data_o    (char_w),
    .par_bit_o (par_bit),
    .stop_bit_o(stop_bit),
    .done_o    (done)
  );

  serial_rx_parity u_par (
    .data_i   (char_w),
    .even_i   (par_even_i),
    .stick_i  (par_stick_i),
    .exp_bit_o(exp_par)
  );

  assign perr_d = par_en_i && (par_bit != exp_par);
  assign ferr_d = ~stop_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      valid_o <= done;
      perr_o  <= done && perr_d;
      ferr_o  <= done && ferr_d;
      irq_o   <= done && lsi_en_i && (perr_d || ferr_d);
      if (done) data_o <= char_w;
    end
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] wlen_i,
  input logic       par_en_i,
  input logic       lsi_en_i,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       irq_o
);
  // R8: strobe lasts one clock
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8: flags only alongside the strobe
  p_flags_need_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o || ferr_o) |-> valid_o);

  // R9: interrupt only with an error on a strobed character
  p_irq_needs_error_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (valid_o && (perr_o || ferr_o)));

  // R9: interrupt gated by enable
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsi_en_i |-> !irq_o);

  // R1: 5-bit words leave upper bits zero
  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wlen_i == 2'b00) |-> (data_o[7:5] == 3'b000));

  // R4: no parity error with parity disabled
  p_no_perr_nopar_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !perr_o);
endmodule

bind serial_rx serial_rx_chk u_serial_rx_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wlen_i  (wlen_i),
  .par_en_i(par_en_i),
  .lsi_en_i(lsi_en_i),
  .data_o  (data_o),
  .valid_o (valid_o),
  .perr_o  (perr_o),
  .ferr_o  (ferr_o),
  .irq_o   (irq_o)
);

// File: tb/test_serial_rx.sv
module test_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int NVEC       = 8;

  // {wlen[15:14], pen[13], even[12], stick[11], lsi[10], data[9:2], bad_par[1], bad_stop[0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b1, 1'b0},
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] wlen_i = 2'b11;
  logic       stop2_i = 1'b0;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic       par_stick_i = 1'b0;
  logic       lsi_en_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, perr_o, ferr_o, irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int tdiv = 0;

  int         n_valid = 0;
  logic [7:0] cap_data [4];
  logic       cap_perr [4];
  logic       cap_ferr [4];
  logic       cap_irq  [4];

  serial_rx i_serial_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .wlen_i(wlen_i), .stop2_i(stop2_i), .par_en_i(par_en_i),
    .par_even_i(par_even_i), .par_stick_i(par_stick_i), .lsi_en_i(lsi_en_i),
    .data_o(data_o), .valid_o(valid_o), .perr_o(perr_o), .ferr_o(ferr_o),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_i <= (tdiv == TICK_DIV - 1);
  end

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (n_valid < 4) begin
        cap_data[n_valid] = data_o;
        cap_perr[n_valid] = perr_o;
        cap_ferr[n_valid] = ferr_o;
        cap_irq[n_valid]  = irq_o;
      end
      n_valid++;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    rxd_i = v;
    repeat (BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic pbit, input logic stopv, input int idle_bits);
    hold(1'b0);
    for (int i = 0; i < nb; i++) hold(d[i]);
    if (pen) hold(pbit);
    hold(stopv);
    for (int i = 0; i < idle_bits; i++) hold(1'b1);
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int nb,
                                   input logic even, input logic stick);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    if (stick) return ~even;
    return even ? p : ~p;
  endfunction

  function automatic logic [7:0] mask_of(input int nb);
    return 8'((9'd1 << nb) - 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    // R10: reset state
    chk("R10", "data", int'(data_o), 0);
    chk("R10", "valid", int'(valid_o), 0);
    chk("R10", "flags", int'({perr_o, ferr_o, irq_o}), 0);
    rst_ni = 1'b1;
    repeat (BIT_CLKS) @(negedge clk_i);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e;
      int nb;
      logic pb, ep, ef, ei;
      string ptag;
      e = VEC[v];
      wlen_i      = e[15:14];
      par_en_i    = e[13];
      par_even_i  = e[12];
      par_stick_i = e[11];
      lsi_en_i    = e[10];
      nb = 5 + int'(e[15:14]);
      pb = exp_par(e[9:2], nb, e[12], e[11]) ^ e[1];
      ep = e[13] & e[1];
      ef = e[0];
      ei = e[10] & (ep | ef);
      ptag = !e[13] ? "R4" : (e[11] ? "R3" : "R2");
      n_valid = 0;
      send_frame(e[9:2], nb, e[13], pb, ~e[0], 2);
      chk("R8", $sformatf("vec%0d strobes", v), n_valid, 1);
      chk("R1", $sformatf("vec%0d data", v), int'(cap_data[0]), int'(e[9:2] & mask_of(nb)));
      chk(ptag, $sformatf("vec%0d perr", v), int'(cap_perr[0]), int'(ep));
      chk("R6", $sformatf("vec%0d ferr", v), int'(cap_ferr[0]), int'(ef));
      chk("R9", $sformatf("vec%0d irq", v), int'(cap_irq[0]), int'(ei));
    end

    // R7: short low glitch rejected
    wlen_i = 2'b11; par_en_i = 1'b0; lsi_en_i = 1'b1;
    n_valid = 0;
    rxd_i = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk_i);
    chk("R7", "glitch strobes", n_valid, 0);
    n_valid = 0;
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, 2);
    chk("R7", "frame after glitch", int'(cap_data[0]), 8'hC3);

    // R5: two-stop mode, next start right after first stop
    stop2_i = 1'b1; par_en_i = 1'b1; par_even_i = 1'b1; par_stick_i = 1'b0;
    n_valid = 0;
    send_frame(8'h81, 8, 1'b1, exp_par(8'h81, 8, 1'b1, 1'b0), 1'b1, 0);
    send_frame(8'h6E, 8, 1'b1, exp_par(8'h6E, 8, 1'b1, 1'b0), 1'b1, 2);
    chk("R5", "back-to-back strobes", n_valid, 2);
    chk("R5", "first char", int'(cap_data[0]), 8'h81);
    chk("R5", "second char", int'(cap_data[1]), 8'h6E);
    chk("R5", "errors", int'({cap_perr[0], cap_ferr[0], cap_perr[1], cap_ferr[1]}), 0);

    // R4: parity off, select/sticky toggled, data bit 1 right before stop
    stop2_i = 1'b0; par_en_i = 1'b0; par_even_i = 1'b0; par_stick_i = 1'b1;
    wlen_i = 2'b01;
    n_valid = 0;
    send_frame(8'h20, 6, 1'b0, 1'b0, 1'b1, 2);
    chk("R4", "nopar data", int'(cap_data[0]), 8'h20);
    chk("R4", "nopar perr", int'(cap_perr[0]), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule